// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Status and Interrupt Logic

This block builds the line status byte, the interrupt identification byte and the interrupt line for a UART with 64-entry receive and transmit FIFOs. The FIFO storage, the serial shifters and the baud generator sit outside it. It watches the receive fill level, the push and pop strobes, and the error tags that travel with each character. It also sees the transmit FIFO empty flag, the transmit shifter idle flag and a 2-bit receive trigger code.

The receive interrupt follows the fill level and a threshold picked by the trigger code. It rises when the level reaches the threshold and falls again on its own when the level drops below it, with no acknowledge from the host. A transmit-empty interrupt can also be enabled. If every enable bit is clear, the line stays low and the host can poll the status byte instead. A small register port writes the enable bits and the FIFO-enable bit. A status read clears the sticky error flags.

Top module: `uart_fifo_stat_irq`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly when the receive fill level is nonzero.
- R2: A push whose overrun, parity, framing or break flag is set makes status bit 1, 2, 3 or 4 respectively 1 from the next clock edge on. The bit stays set until it is cleared.
- R3: A host read of the status byte (host_rd with address 3) clears status bits 4:1 at that clock edge. The clear wins over a set from a push at the same edge.
- R4: Status bit 5 equals tx_fifo_empty. Status bit 6 is 1 only when tx_fifo_empty and tx_shift_idle are both 1.
- R5: Status bit 7 is 1 while at least one character pushed with a parity, framing or break flag is still in the receive FIFO. It is counted up at the push and down at a pop whose rx_pop_err is 1.
- R6: Trigger codes 0, 1, 2 and 3 select thresholds of 1, 16, 32 and 56 entries. With the FIFO enabled, the receive source is active when level >= threshold. With the FIFO disabled, the threshold is 1.
- R7: The receive interrupt and its identification code clear by themselves as soon as the level drops below the threshold. No register access is needed.
- R8: With enable bit 1 set, the transmit source is active whenever tx_fifo_empty is 1.
- R9: irq is the OR of the receive source gated by enable bit 0 and the transmit source gated by enable bit 1. With enable bits 3:0 all zero, irq stays 0 while the status byte still reports the receive and transmit state.
- R10: Identification bits 3:0 read 0001 when no source is enabled and active, 0100 for receive and 0010 for transmit. Receive wins when both are active. Bits 7:6 read 11 when the FIFO is enabled and 00 otherwise. Bits 5:4 read 0.
- R11: Register map. Address 0 is the enable register: it writes and reads back bits 3:0, and bits 7:4 read 0. Address 1 holds the FIFO enable in bit 0, and bits 7:1 read 0. Address 2 reads the identification byte. Address 3 reads the status byte.
- R12: After reset the enable bits and the FIFO enable are 0, status bits 4:1 and 7 are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Receive FIFO fill level |
| rx_push | input | 1 | A character enters the receive FIFO |
| rx_push_flags | input | 4 | Push error tags: [0] overrun, [1] parity, [2] framing, [3] break |
| rx_pop | input | 1 | A character leaves the receive FIFO |
| rx_pop_err | input | 1 | The leaving character carries an error tag |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_idle | input | 1 | Transmit shift register empty |
| trig_sel | input | 2 | Receive trigger code |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears sticky errors on address 3) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can land on the same clock edge. A status read clears the sticky error flags while a push sets a new one, and a pop takes away an errored entry while a push adds one. The bench drives a framing push in the same cycle as a status read. It expects bits 4:1 to be zero afterwards and the errored-entry count, seen through bit 7, to keep the new entry. The receive and transmit sources active together are judged through the identification code, where receive must win.

// File: rtl/uart_fifo_stat_irq_pkg.sv
package uart_fifo_stat_irq_pkg;
   localparam int unsigned REG_W = 8;
   localparam int unsigned ADR_W = 2;

   localparam logic [ADR_W-1:0] ADR_ENA   = 2'd0;
   localparam logic [ADR_W-1:0] ADR_FCTL  = 2'd1;
   localparam logic [ADR_W-1:0] ADR_IDENT = 2'd2;
   localparam logic [ADR_W-1:0] ADR_STAT  = 2'd3;

   localparam int unsigned ERR_N = 4;
   localparam int unsigned ENA_W = 4;

   typedef enum logic [3:0] {
      ID_NONE = 4'b0001,
      ID_TXE  = 4'b0010,
      ID_RXD  = 4'b0100
   } irq_id_e;
endpackage

// File: rtl/uart_fifo_stat_irq_regs.sv
module uart_fifo_stat_irq_regs
   import uart_fifo_stat_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [ADR_W-1:0] addr,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] ident,
   input  logic [REG_W-1:0] stat,
   output logic [ENA_W-1:0] ena_q,
   output logic             fifo_en_q,
   output logic [REG_W-1:0] rdata
);
   localparam int unsigned PAD_E = REG_W - ENA_W;

   logic unused_wbits;
   assign unused_wbits = ^wdata[REG_W-1:ENA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q     <= '0;
         fifo_en_q <= 1'b0;
      end else if (wr) begin
         if (addr == ADR_ENA)  ena_q     <= wdata[ENA_W-1:0];
         if (addr == ADR_FCTL) fifo_en_q <= wdata[0];
      end
   end

   always_comb begin
      unique case (addr)
         ADR_ENA:   rdata = {{PAD_E{1'b0}}, ena_q};
         ADR_FCTL:  rdata = {{(REG_W-1){1'b0}}, fifo_en_q};
         ADR_IDENT: rdata = ident;
         default:   rdata = stat;
      endcase
   end
endmodule

// File: rtl/uart_fifo_stat_irq_errs.sv
module uart_fifo_stat_irq_errs
   import uart_fifo_stat_irq_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 64
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ERR_N-1:0] flags,
   input  logic             pop,
   input  logic             pop_err,
   input  logic             clr,
   output logic [ERR_N-1:0] sticky_q,
   output logic             held_err
);
   localparam int unsigned CNT_W = $clog2(RX_DEPTH + 1);

   logic [ERR_N-1:0] sticky_d;
   logic [CNT_W-1:0] cnt_q;
   logic             inc, dec;

   for (genvar i = 0; i < ERR_N; i++) begin : g_sticky
      assign sticky_d[i] = clr ? 1'b0 : (sticky_q[i] | (push & flags[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= sticky_d;
   end

   // data errors only: overrun marks a lost character, not a held one
   assign inc = push & (|flags[ERR_N-1:1]) & (cnt_q != CNT_W'(RX_DEPTH));
   assign dec = pop & pop_err & (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (inc & !dec) cnt_q <= cnt_q + 1'b1;
      else if (dec & !inc) cnt_q <= cnt_q - 1'b1;
   end

   assign held_err = (cnt_q != '0);
endmodule

// File: rtl/uart_fifo_stat_irq_gen.sv
module uart_fifo_stat_irq_gen
   import uart_fifo_stat_irq_pkg::*;
#(
   parameter int unsigned LVL_W   = 7,
   parameter int unsigned THR_C0  = 1,
   parameter int unsigned THR_C1  = 16,
   parameter int unsigned THR_C2  = 32,
   parameter int unsigned THR_C3  = 56,
   parameter bit          IRQ_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [1:0]       trig_sel,
   input  logic             fifo_en,
   input  logic [1:0]       ena,
   input  logic             tx_empty,
   output logic [REG_W-1:0] ident,
   output logic             irq
);
   logic [LVL_W-1:0] thr;
   logic             rx_src, tx_src, irq_c;
   irq_id_e          code;

   always_comb begin
      if (!fifo_en) thr = LVL_W'(1);
      else begin
         unique case (trig_sel)
            2'd0:    thr = LVL_W'(THR_C0);
            2'd1:    thr = LVL_W'(THR_C1);
            2'd2:    thr = LVL_W'(THR_C2);
            default: thr = LVL_W'(THR_C3);
         endcase
      end
   end

   assign rx_src = ena[0] & (level >= thr);
   assign tx_src = ena[1] & tx_empty;
   assign irq_c  = rx_src | tx_src;

   always_comb begin
      if (rx_src)      code = ID_RXD;
      else if (tx_src) code = ID_TXE;
      else             code = ID_NONE;
   end

   assign ident = {fifo_en, fifo_en, 2'b00, code};

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_c;
      end
   end else begin : g_irq_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = irq_c;
   end
endmodule

// File: rtl/uart_fifo_stat_irq.sv
module uart_fifo_stat_irq
   import uart_fifo_stat_irq_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 64,
   parameter int unsigned THR_C0   = 1,
   parameter int unsigned THR_C1   = 16,
   parameter int unsigned THR_C2   = 32,
   parameter int unsigned THR_C3   = 56,
   parameter bit          IRQ_REG  = 1'b0,
   localparam int unsigned LVL_W   = $clog2(RX_DEPTH + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_push,
   input  logic [3:0]       rx_push_flags,
   input  logic             rx_pop,
   input  logic             rx_pop_err,
   input  logic             tx_fifo_empty,
   input  logic             tx_shift_idle,
   input  logic [1:0]       trig_sel,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [1:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             irq
);
   if (THR_C0 < 1 || THR_C0 > THR_C1 || THR_C1 > THR_C2 || THR_C2 > THR_C3
       || THR_C3 > RX_DEPTH) begin : g_bad_thr
      $error("trigger thresholds must rise from 1 up to RX_DEPTH");
   end
   if (RX_DEPTH < 2) begin : g_bad_depth
      $error("RX_DEPTH must be at least 2");
   end

   logic [ENA_W-1:0] ena_q;
   logic             fifo_en_q;
   logic [ERR_N-1:0] sticky_q;
   logic             held_err;
   logic [REG_W-1:0] stat_w, ident_w;
   logic             stat_rd;

   assign stat_rd = host_rd & (host_addr == ADR_STAT);

   assign stat_w = {held_err,
                    tx_fifo_empty & tx_shift_idle,
                    tx_fifo_empty,
                    sticky_q,
                    (rx_level != '0)};

   uart_fifo_stat_irq_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (host_wr),
      .addr      (host_addr),
      .wdata     (host_wdata),
      .ident     (ident_w),
      .stat      (stat_w),
      .ena_q     (ena_q),
      .fifo_en_q (fifo_en_q),
      .rdata     (host_rdata)
   );

   uart_fifo_stat_irq_errs #(.RX_DEPTH(RX_DEPTH)) u_errs (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (rx_push),
      .flags    (rx_push_flags),
      .pop      (rx_pop),
      .pop_err  (rx_pop_err),
      .clr      (stat_rd),
      .sticky_q (sticky_q),
      .held_err (held_err)
   );

   uart_fifo_stat_irq_gen #(
      .LVL_W   (LVL_W),
      .THR_C0  (THR_C0),
      .THR_C1  (THR_C1),
      .THR_C2  (THR_C2),
      .THR_C3  (THR_C3),
      .IRQ_REG (IRQ_REG)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (rx_level),
      .trig_sel (trig_sel),
      .fifo_en  (fifo_en_q),
      .ena      (ena_q[1:0]),
      .tx_empty (tx_fifo_empty),
      .ident    (ident_w),
      .irq      (irq)
   );
endmodule

// File: rtl/uart_fifo_stat_irq_chk.sv
module uart_fifo_stat_irq_chk #(
   parameter int unsigned LVL_W = 7
)(
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level,
   input logic             rx_push,
   input logic             stat_rd,
   input logic [7:0]       stat_w,
   input logic [7:0]       ident_w,
   input logic [3:0]       ena_q,
   input logic             tx_fifo_empty,
   input logic             irq
);
   AST_DR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !stat_w[0]);  // R1
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !rx_push) |=> $stable(stat_w[4:1]));  // R2
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (stat_w[4:1] == 4'h0));  // R3
   AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_w[6] |-> stat_w[5]);  // R4
   AST_TX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q[1] && tx_fifo_empty) |-> (ident_w[3:0] != 4'b0001));  // R8
   AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((ena_q == 4'h0) && ($past(ena_q) == 4'h0)) |-> !irq);  // R9
   AST_ID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ident_w[3:0]) && (ident_w[5:4] == 2'b00));  // R10
endmodule

bind uart_fifo_stat_irq uart_fifo_stat_irq_chk #(.LVL_W(LVL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_level      (rx_level),
   .rx_push       (rx_push),
   .stat_rd       (stat_rd),
   .stat_w        (stat_w),
   .ident_w       (ident_w),
   .ena_q         (ena_q),
   .tx_fifo_empty (tx_fifo_empty),
   .irq           (irq)
);

// File: tb/uart_fifo_stat_irq_bench.sv
module uart_fifo_stat_irq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] rx_level = '0;
   logic       rx_push = 1'b0;
   logic [3:0] rx_push_flags = '0;
   logic       rx_pop = 1'b0;
   logic       rx_pop_err = 1'b0;
   logic       tx_fifo_empty = 1'b0;
   logic       tx_shift_idle = 1'b0;
   logic [1:0] trig_sel = '0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_fifo_stat_irq u_uart_fifo_stat_irq (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_push(rx_push),
      .rx_push_flags(rx_push_flags), .rx_pop(rx_pop), .rx_pop_err(rx_pop_err),
      .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
      .trig_sel(trig_sel), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq(irq)
   );

   // {fifo_en, ena[1:0], trig[1:0], level[6:0], tx_empty, exp_irq, exp_ident[7:0]}
   localparam int NV = 15;
   localparam logic [21:0] VEC [NV] = '{
      {1'b1, 2'b01, 2'd0, 7'd0,  1'b0, 1'b0, 8'hC1},
      {1'b1, 2'b01, 2'd0, 7'd1,  1'b0, 1'b1, 8'hC4},
      {1'b1, 2'b01, 2'd1, 7'd15, 1'b0, 1'b0, 8'hC1},
      {1'b1, 2'b01, 2'd1, 7'd16, 1'b0, 1'b1, 8'hC4},
      {1'b1, 2'b01, 2'd2, 7'd31, 1'b0, 1'b0, 8'hC1},
      {1'b1, 2'b01, 2'd2, 7'd32, 1'b0, 1'b1, 8'hC4},
      {1'b1, 2'b01, 2'd3, 7'd55, 1'b0, 1'b0, 8'hC1},
      {1'b1, 2'b01, 2'd3, 7'd56, 1'b0, 1'b1, 8'hC4},
      {1'b1, 2'b01, 2'd3, 7'd64, 1'b0, 1'b1, 8'hC4},
      {1'b1, 2'b11, 2'd3, 7'd20, 1'b1, 1'b1, 8'hC2},
      {1'b1, 2'b11, 2'd3, 7'd60, 1'b1, 1'b1, 8'hC4},
      {1'b1, 2'b10, 2'd3, 7'd60, 1'b1, 1'b1, 8'hC2},
      {1'b1, 2'b00, 2'd0, 7'd60, 1'b1, 1'b0, 8'hC1},
      {1'b0, 2'b01, 2'd3, 7'd1,  1'b0, 1'b1, 8'h04},
      {1'b0, 2'b01, 2'd3, 7'd0,  1'b1, 1'b0, 8'h01}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   // peek: combinational read, no strobe
   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      host_addr = a; #2;
      d = host_rdata;
   endtask

   // status read with strobe: sample, then clear at the next edge
   task automatic stat_read(output logic [7:0] d);
      @(posedge clk); #1;
      host_addr = 2'd3; host_rd = 1'b1; #2;
      d = host_rdata;
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic push_one(input logic [3:0] f, input logic [6:0] new_lvl, input bit with_rd);
      @(posedge clk); #1;
      rx_push = 1'b1; rx_push_flags = f;
      if (with_rd) begin host_addr = 2'd3; host_rd = 1'b1; end
      @(posedge clk); #1;
      rx_push = 1'b0; rx_push_flags = '0; host_rd = 1'b0;
      rx_level = new_lvl;
   endtask

   task automatic pop_one(input bit errd, input logic [6:0] new_lvl);
      @(posedge clk); #1;
      rx_pop = 1'b1; rx_pop_err = errd;
      @(posedge clk); #1;
      rx_pop = 1'b0; rx_pop_err = 1'b0;
      rx_level = new_lvl;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      tx_fifo_empty = 1'b1; tx_shift_idle = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state: R12
      #2;
      chk("R12 irq", {7'b0, irq}, 8'h00);
      peek(2'd3, d); chk("R12 status", d, 8'h60);
      peek(2'd0, d); chk("R12 enables", d, 8'h00);
      peek(2'd1, d); chk("R12 fifo enable", d, 8'h00);
      peek(2'd2, d); chk("R12/R10 ident", d, 8'h01);

      // R4 transmit status bits
      tx_shift_idle = 1'b0; #2;
      peek(2'd3, d); chk("R4 tx empty, shifter busy", d, 8'h20);
      tx_fifo_empty = 1'b0; #2;
      peek(2'd3, d); chk("R4 tx busy", d, 8'h00);

      // R11 register map readback
      host_write(2'd0, 8'hFA);
      peek(2'd0, d); chk("R11 enable readback", d, 8'h0A);
      host_write(2'd1, 8'hFF);
      peek(2'd1, d); chk("R11 fifo ctl readback", d, 8'h01);
      host_write(2'd0, 8'h00);

      // table walk: R6 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         host_write(2'd1, {7'b0, VEC[i][21]});
         host_write(2'd0, {6'b0, VEC[i][20:19]});
         @(posedge clk); #1;
         trig_sel = VEC[i][18:17]; rx_level = VEC[i][16:10]; tx_fifo_empty = VEC[i][9];
         #2;
         chk($sformatf("R6/R8/R9 irq vec %0d", i), {7'b0, irq}, {7'b0, VEC[i][8]});
         peek(2'd2, d);
         chk($sformatf("R10 ident vec %0d", i), d, VEC[i][7:0]);
      end

      // R9 polled mode still reports status
      host_write(2'd0, 8'h00);
      host_write(2'd1, 8'h01);
      @(posedge clk); #1;
      rx_level = 7'd3; tx_fifo_empty = 1'b1; tx_shift_idle = 1'b1; #2;
      chk("R9 polled irq", {7'b0, irq}, 8'h00);
      peek(2'd3, d); chk("R9 polled status", d, 8'h61);

      // R7 automatic clear
      host_write(2'd0, 8'h01);
      @(posedge clk); #1;
      tx_fifo_empty = 1'b0; tx_shift_idle = 1'b0;
      trig_sel = 2'd3; rx_level = 7'd56; #2;
      chk("R7 raised", {7'b0, irq}, 8'h01);
      @(posedge clk); #1;
      rx_level = 7'd55; #2;
      chk("R7 self clear irq", {7'b0, irq}, 8'h00);
      peek(2'd2, d); chk("R7 self clear ident", d, 8'hC1);
      host_write(2'd0, 8'h00);

      // R1 data ready empty
      @(posedge clk); #1;
      rx_level = 7'd0; #2;
      peek(2'd3, d); chk("R1 empty", d, 8'h00);

      // R2 R5 parity push
      push_one(4'b0010, 7'd1, 1'b0);
      peek(2'd3, d); chk("R2/R5/R1 parity push", d, 8'h85);
      // R3 read returns then clears; R3 clear beats framing set
      stat_read(d); chk("R3 read value", d, 8'h85);
      peek(2'd3, d); chk("R3 cleared", d, 8'h81);
      push_one(4'b0100, 7'd2, 1'b1);
      peek(2'd3, d); chk("R3 clear wins over set", d, 8'h81);
      // R5 pops of errored entries
      pop_one(1'b1, 7'd1);
      peek(2'd3, d); chk("R5 one errored left", d, 8'h81);
      pop_one(1'b1, 7'd0);
      peek(2'd3, d); chk("R5 none left", d, 8'h00);
      // R2 overrun does not count as a held error
      push_one(4'b0001, 7'd1, 1'b0);
      peek(2'd3, d); chk("R2 overrun", d, 8'h03);
      push_one(4'b1000, 7'd2, 1'b0);
      peek(2'd3, d); chk("R2 break", d, 8'h93);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule